// File: doc/BRIEF.md
# Self-Recovering JK Divide-by-Five

This block divides its input clock by five. Three state bits are updated on every rising clock edge. Each bit's next value follows the characteristic equation of a JK flip-flop. The J and K terms are taken from the present state. With this wiring the machine runs through the non-binary loop 1, 3, 5, 2, 4. The typical use is turning a 50 MHz reference into 10 MHz.

Three codes (0, 6, 7) lie outside the loop. Code 0 would hold itself under the plain JK wiring, so a small correction term sends it to 1. Code 7 falls into 0 and then into 1. Code 6 reaches 1 on its own. A load port can place any code into the state register, which lets recovery from every illegal code be exercised. A terminal pulse marks the last state of each loop.

The divided output has two forms. With the symmetric mode off, it is a rising-edge term that is high for two of the five input periods. With the mode on, a copy of that term is captured on the falling edge and ORed with it, which stretches the high time to 2.5 periods.

Top module: `divfive_jk`

## Requirements
- R1: With reset and load low, the state output (bit 2 most significant) advances on each rising edge along 1 → 3 → 5 → 2 → 4 → 1.
- R2: A high synchronous reset puts code 1 on the state output after the next rising edge. Reset wins over a simultaneous load. After reset, tc and div_out are low.
- R3: With reset and load low, code 0 goes to 1, code 6 goes to 1 and code 7 goes to 0. Every illegal code is back inside the loop within two rising edges.
- R4: tc is high exactly in the clock periods in which the state is 4, which is once every five input clocks.
- R5: When load is high and reset is low, the state output takes load_value after the next rising edge, whether the value is legal or illegal.
- R6: With sym_en low, div_out is high while the state is 3 or 5 and low otherwise. That is two of every five input periods, aligned to rising edges.
- R7: With sym_en high, div_out rises when the state enters 3 and falls half an input period after the state enters 2. That is 2.5 high and 2.5 low input periods per cycle, with no low gap where the two terms overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high, loads code 1 |
| load | input | 1 | Writes load_value into the state register on the next rising edge |
| load_value | input | 3 | Code to be written by load |
| sym_en | input | 1 | Selects the 2.5/2.5 symmetric output |
| state | output | 3 | Present state code, bit 2 most significant |
| tc | output | 1 | Terminal pulse, high while the state is 4 |
| div_out | output | 1 | Divided clock output |

## Verification
Reset and load can request the same rising edge, and the register can hold only one result. The bench raises both, with load_value set to 5, and requires the state to show 1 afterwards. The other overlap is between the loop and recovery. Each of the eight codes is loaded in turn, and the first one or two successors are compared with a model worked out from the requirements. This shows that forced codes rejoin the normal order and do not jump into it at the wrong point.

// File: rtl/divfive_pkg.sv
package divfive_pkg;
    localparam int STATE_W = 3;
    typedef logic [STATE_W-1:0] state_t;

    localparam state_t S_START = 3'd1;
    localparam state_t S_SECOND = 3'd3;
    localparam state_t S_THIRD = 3'd5;
    localparam state_t S_TERM = 3'd4;
    localparam state_t S_TRAP = 3'd0;

    typedef struct packed {
        state_t st;
        logic   hi;
    } core_regs_t;
endpackage

// File: rtl/divfive_jk_stage.sv
module divfive_jk_stage (
    input  logic j,
    input  logic k,
    input  logic q,
    output logic q_next
);
    always_comb begin
        q_next = (j & ~q) | (~k & q);
    end
endmodule

// File: rtl/divfive_jk_next.sv
module divfive_jk_next
    import divfive_pkg::*;
(
    input  state_t cur,
    output state_t nxt
);
    localparam int B1 = STATE_W - 1;
    localparam int B2 = STATE_W - 2;
    localparam int B3 = STATE_W - 3;

    logic [STATE_W-1:0] j_in;
    logic [STATE_W-1:0] k_in;
    state_t raw;

    always_comb begin
        j_in[B1] = cur[B2];
        k_in[B1] = cur[B1];
        j_in[B2] = cur[B3];
        k_in[B2] = cur[B2];
        j_in[B3] = cur[B1];
        k_in[B3] = cur[B1];
    end

    genvar gi;
    generate
        for (gi = 0; gi < STATE_W; gi++) begin : g_ff
            divfive_jk_stage u_stage (
                .j      (j_in[gi]),
                .k      (k_in[gi]),
                .q      (cur[gi]),
                .q_next (raw[gi])
            );
        end
    endgenerate

    always_comb begin
        nxt = (cur == S_TRAP) ? S_START : raw;
    end
endmodule

// File: rtl/divfive_shaper.sv
module divfive_shaper (
    input  logic clk,
    input  logic rst,
    input  logic sym_en,
    input  logic hi_q,
    output logic div_out
);
    logic half_d;
    logic half_q;

    always_comb begin
        half_d = rst ? 1'b0 : hi_q;
    end

    always_ff @(negedge clk) begin
        half_q <= half_d;
    end

    always_comb begin
        div_out = hi_q | (sym_en & half_q);
    end
endmodule

// File: rtl/divfive_jk.sv
module divfive_jk
    import divfive_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [STATE_W-1:0] load_value,
    input  logic               sym_en,
    output logic [STATE_W-1:0] state,
    output logic               tc,
    output logic               div_out
);
    core_regs_t regs_d;
    core_regs_t regs_q;
    state_t     jk_nxt;

    divfive_jk_next u_next (
        .cur (regs_q.st),
        .nxt (jk_nxt)
    );

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d.st = S_START;
        end else if (load) begin
            regs_d.st = load_value;
        end else begin
            regs_d.st = jk_nxt;
        end
        regs_d.hi = (regs_d.st == S_SECOND) || (regs_d.st == S_THIRD);
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    divfive_shaper u_shape (
        .clk     (clk),
        .rst     (rst),
        .sym_en  (sym_en),
        .hi_q    (regs_q.hi),
        .div_out (div_out)
    );

    always_comb begin
        state = regs_q.st;
        tc    = (regs_q.st == S_TERM);
    end
endmodule

module divfive_jk_chk (
    input logic       clk,
    input logic       rst,
    input logic       load,
    input logic [2:0] state,
    input logic       tc
);
    function automatic logic [2:0] succ(input logic [2:0] s);
        case (s)
            3'd1:    succ = 3'd3;
            3'd3:    succ = 3'd5;
            3'd5:    succ = 3'd2;
            3'd2:    succ = 3'd4;
            default: succ = 3'd1;
        endcase
    endfunction

    logic rst_seen_q = 1'b0;
    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    always @(posedge clk) begin
        if (rst_seen_q) begin
            AST_RESET_GIVES_ONE: assert (state == 3'd1); // R2
        end
    end

    AST_LOOP_ORDER: assert property (@(posedge clk) disable iff (rst)
        (!load && (state == 3'd1 || state == 3'd3 || state == 3'd5 ||
                   state == 3'd2 || state == 3'd4))
        |=> (rst || load || state == succ($past(state)))); // R1

    AST_ZERO_ESCAPES: assert property (@(posedge clk) disable iff (rst)
        (!load && state == 3'd0) |=> (rst || load || state == 3'd1)); // R3

    AST_SEVEN_FALLS: assert property (@(posedge clk) disable iff (rst)
        (!load && state == 3'd7) |=> (rst || load || state == 3'd0)); // R3

    AST_TC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (tc && !load) |=> (rst || load || (!tc && state == 3'd1))); // R4
endmodule

bind divfive_jk divfive_jk_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .state (state),
    .tc    (tc)
);

// File: tb/divfive_jk_test.sv
`timescale 1ns/1ps
module divfive_jk_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic [2:0] load_value = 3'd0;
    logic       sym_en = 1'b0;
    logic [2:0] state;
    logic       tc;
    logic       div_out;

    int  n_run = 0;
    int  n_fail = 0;
    logic sa, sb;
    bit  finished = 0;

    always #10 clk = ~clk;

    divfive_jk uut (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_value (load_value),
        .sym_en     (sym_en),
        .state      (state),
        .tc         (tc),
        .div_out    (div_out)
    );

    function automatic logic [2:0] model_next(input logic [2:0] s);
        case (s)
            3'd1: model_next = 3'd3;
            3'd3: model_next = 3'd5;
            3'd5: model_next = 3'd2;
            3'd2: model_next = 3'd4;
            3'd4: model_next = 3'd1;
            3'd0: model_next = 3'd1;
            3'd6: model_next = 3'd1;
            default: model_next = 3'd0;
        endcase
    endfunction

    function automatic bit in_loop(input logic [2:0] s);
        in_loop = (s == 3'd1 || s == 3'd3 || s == 3'd5 || s == 3'd2 || s == 3'd4);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #5 sa = div_out;
        #10 sb = div_out;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] e;
        logic [2:0] prev;
        int highs, tcs;
        step;
        step;
        rst = 1'b0;
        check("R2 reset state", state, 1);
        check("R2 reset tc", tc, 0);
        check("R2 reset div_out", sb, 0);

        e = 3'd1;
        for (int i = 0; i < 15; i++) begin
            step;
            e = model_next(e);
            check("R1 loop order", state, e);
            check("R4 tc decode", tc, (e == 3'd4));
        end

        for (int v = 0; v < 8; v++) begin
            load = 1'b1;
            load_value = v[2:0];
            step;
            load = 1'b0;
            check("R5 load value", state, v);
            step;
            e = model_next(v[2:0]);
            check(in_loop(v[2:0]) ? "R1 after load" : "R3 first escape", state, e);
            if (!in_loop(e)) begin
                step;
                e = model_next(e);
                check("R3 second escape", state, e);
            end
            check("R3 back in loop", in_loop(state), 1);
        end

        rst = 1'b1;
        load = 1'b1;
        load_value = 3'd5;
        step;
        rst = 1'b0;
        load = 1'b0;
        check("R2 reset beats load", state, 1);

        for (int m = 0; m < 2; m++) begin
            sym_en = m[0];
            for (int w = 0; w < 5; w++) step;
            prev = state;
            highs = 0;
            tcs = 0;
            for (int c = 0; c < 10; c++) begin
                step;
                highs += sa + sb;
                tcs += tc;
                if (m == 0) begin
                    check("R6 early half", sa, (state == 3'd3 || state == 3'd5));
                    check("R6 late half", sb, (state == 3'd3 || state == 3'd5));
                end else begin
                    check("R7 early half", sa, (state == 3'd3 || state == 3'd5 ||
                                                prev == 3'd3 || prev == 3'd5));
                    check("R7 late half", sb, (state == 3'd3 || state == 3'd5));
                end
                prev = state;
            end
            check(m == 0 ? "R6 high half-periods" : "R7 high half-periods",
                  highs, (m == 0) ? 8 : 10);
            check("R4 pulses per ten clocks", tcs, 2);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule